// File: doc/BRIEF.md
# Frame-Slot GPIO Bridge

This block ties a bank of general-purpose pins to a time-slotted serial link. The link's framing logic hands it one parallel 20-bit control word per frame and a one-cycle frame strobe. In return it takes a 20-bit status word that it shifts back to the controller. Pins whose direction bit is set are driven from the matching control-word bits. Every pin's synchronized level is captured into the status word at each frame strobe, so a full frame always reports one coherent snapshot.

A small write port loads three pin-wide registers: the pin direction, the pin data value and the per-pin change-interrupt enable. The data value can be loaded while a pin is still an input. As soon as the direction bit is set, the pin drives that value, so software can set the level first and turn the driver on afterwards. Input pins that change level between frames set sticky per-pin flags. The logical OR of these flags is reported on an interrupt output and in bit 0 of the status word. A write-one-to-clear mask clears the flags.

Top module: `gpio_slot_bridge`

## Requirements
- R1: While reset is asserted and just after it is released, `pin_oe`, `pin_out`, `sta_slot` and `irq` are all zero, so every pin is high-impedance.
- R2: A write with `cfg_sel`=0 loads the direction register (bit n = 1 makes pin n an output), and `pin_oe` shows the new value on the next clock.
- R3: A write with `cfg_sel`=1 loads the data register on the next clock, whatever the pin direction. `pin_out` always shows the data register.
- R4: A control word marked by `ctl_valid` is applied at the first `frame_stb` strictly after that clock. Slot bit n+4 sets the data bit of output pin n. A word whose valid clock coincides with a strobe waits for the following strobe.
- R5: Control-word bits that belong to input pins leave those pins' data bits unchanged.
- R6: If no valid control word arrives between two strobes, the pin data holds its value.
- R7: At each `frame_stb`, status bit n+4 takes the level of pin n after a two-flop synchronizer. `sta_slot` holds that value until the next strobe.
- R8: A data value applied at a strobe is absent from the status latched at that same strobe, and appears at a later strobe.
- R9: Status bits 3:1 and every bit above the last pin field always read zero.
- R10: At a strobe, a pin's sticky flag is set only if the pin is an input, its enable bit (`cfg_sel`=2) is set, and its synchronized level differs from the level latched at the previous strobe. The first strobe after reset sets no flag.
- R11: `irq` is the OR of the sticky flags. Status bit 0 is latched at each strobe as that OR, including flags set or cleared in the same cycle.
- R12: Pulsing `irq_clr_we` clears the flags selected by `irq_clr_mask`. A flag set in the same cycle stays set.
- R13: When a `cfg_sel`=1 write and a pending control word land in the same cycle, the write port's value wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_stb | input | 1 | One-cycle frame boundary strobe |
| ctl_slot | input | 20 | Parallel control word from the link |
| ctl_valid | input | 1 | Marks `ctl_slot` valid this cycle |
| sta_slot | output | 20 | Parallel status word to the link |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | 0 direction, 1 data, 2 interrupt enable |
| cfg_wdata | input | NPIN | Register write value |
| irq_clr_we | input | 1 | Write-one-to-clear strobe for sticky flags |
| irq_clr_mask | input | NPIN | Flags cleared by the strobe |
| irq | output | 1 | OR of all sticky change flags |
| pin_in | input | NPIN | Pad levels |
| pin_out | output | NPIN | Pad drive values |
| pin_oe | output | NPIN | Pad output enables |

## Verification
The bench models the pads in a loop, so a driven value returns through the synchronizer. This exposes a design that forwards a new output value into the same frame's status: the status would show the new level one frame early. It drives a pin high before the first strobe after reset, and a design with no priming would raise a false interrupt there. It changes output pins and pins whose enable is clear, where a design with a wrong mask would set a flag. It also collides a clear with a new set, a write-port load with a pending control word, and a valid word with the strobe itself. A design that resolves any of these the wrong way shows a different `irq`, `pin_out` or data timing on the cycle after the collision.

// File: rtl/gsb_pkg.sv
package gsb_pkg;
  localparam int SLOT_W   = 20;
  localparam int PIN_LSB  = 4;
  localparam int FLAG_BIT = 0;

  typedef enum logic [1:0] {
    SEL_DIR  = 2'd0,
    SEL_DATA = 2'd1,
    SEL_IEN  = 2'd2,
    SEL_NONE = 2'd3
  } cfg_sel_e;
endpackage

// File: rtl/gsb_rst_sync.sv
module gsb_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_sync = stage_q[1];
endmodule

// File: rtl/gsb_pin_sync.sv
module gsb_pin_sync #(
  parameter int NPIN = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPIN-1:0] pin_raw,
  output logic [NPIN-1:0] pin_sync
);
  for (genvar i = 0; i < NPIN; i++) begin : g_bit
    logic meta_q, sync_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= 1'b0;
        sync_q <= 1'b0;
      end else begin
        meta_q <= pin_raw[i];
        sync_q <= meta_q;
      end
    end
    assign pin_sync[i] = sync_q;
  end
endmodule

// File: rtl/gsb_ctl_regs.sv
module gsb_ctl_regs
  import gsb_pkg::*;
#(
  parameter int NPIN = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            frame_stb,
  input  logic            ctl_valid,
  input  logic [NPIN-1:0] ctl_bits,
  input  logic            cfg_we,
  input  cfg_sel_e        cfg_sel,
  input  logic [NPIN-1:0] cfg_wdata,
  output logic [NPIN-1:0] dir_q,
  output logic [NPIN-1:0] data_q,
  output logic [NPIN-1:0] ien_q
);
  logic [NPIN-1:0] dir_d, data_d, ien_d;
  logic [NPIN-1:0] pend_q, pend_d;
  logic            pendv_q, pendv_d;

  always_comb begin
    dir_d   = dir_q;
    data_d  = data_q;
    ien_d   = ien_q;
    pend_d  = pend_q;
    pendv_d = pendv_q;
    // apply pending word at the strobe, only to output pins
    if (frame_stb && pendv_q)
      data_d = (data_q & ~dir_q) | (pend_q & dir_q);
    // write port takes priority over the slot word
    if (cfg_we) begin
      unique case (cfg_sel)
        SEL_DIR:  dir_d  = cfg_wdata;
        SEL_DATA: data_d = cfg_wdata;
        SEL_IEN:  ien_d  = cfg_wdata;
        default:  ;
      endcase
    end
    if (ctl_valid) begin
      pend_d  = ctl_bits;
      pendv_d = 1'b1;
    end else if (frame_stb) begin
      pendv_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q   <= '0;
      data_q  <= '0;
      ien_q   <= '0;
      pend_q  <= '0;
      pendv_q <= 1'b0;
    end else begin
      dir_q   <= dir_d;
      data_q  <= data_d;
      ien_q   <= ien_d;
      pendv_q <= pendv_d;
      if (ctl_valid) pend_q <= pend_d;
    end
  end
endmodule

// File: rtl/gsb_irq.sv
module gsb_irq #(
  parameter int NPIN = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            frame_stb,
  input  logic [NPIN-1:0] pin_sync,
  input  logic [NPIN-1:0] dir_q,
  input  logic [NPIN-1:0] ien_q,
  input  logic            clr_we,
  input  logic [NPIN-1:0] clr_mask,
  output logic [NPIN-1:0] sticky_d,
  output logic [NPIN-1:0] sticky_q
);
  logic [NPIN-1:0] prev_q, prev_d;
  logic            primed_q, primed_d;
  logic [NPIN-1:0] set_vec, clr_vec;

  always_comb begin
    set_vec  = (frame_stb && primed_q) ? ((pin_sync ^ prev_q) & ~dir_q & ien_q) : '0;
    clr_vec  = clr_we ? clr_mask : '0;
    sticky_d = (sticky_q & ~clr_vec) | set_vec;
    prev_d   = frame_stb ? pin_sync : prev_q;
    primed_d = primed_q | frame_stb;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q   <= '0;
      primed_q <= 1'b0;
      sticky_q <= '0;
    end else begin
      if (frame_stb) prev_q <= prev_d;
      primed_q <= primed_d;
      sticky_q <= sticky_d;
    end
  end
endmodule

// File: rtl/gpio_slot_bridge.sv
module gpio_slot_bridge
  import gsb_pkg::*;
#(
  parameter int NPIN = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_stb,
  input  logic [SLOT_W-1:0] ctl_slot,
  input  logic              ctl_valid,
  output logic [SLOT_W-1:0] sta_slot,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [NPIN-1:0]   cfg_wdata,
  input  logic              irq_clr_we,
  input  logic [NPIN-1:0]   irq_clr_mask,
  output logic              irq,
  input  logic [NPIN-1:0]   pin_in,
  output logic [NPIN-1:0]   pin_out,
  output logic [NPIN-1:0]   pin_oe
);
  localparam int PIN_MSB = PIN_LSB + NPIN - 1;

  logic            rst_n_i;
  logic [NPIN-1:0] pin_sync, dir_q, data_q, ien_q, sticky_d, sticky_q;
  logic [SLOT_W-1:0] sta_q, sta_d;

  gsb_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_i)
  );

  gsb_pin_sync #(.NPIN(NPIN)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n_i),
    .pin_raw  (pin_in),
    .pin_sync (pin_sync)
  );

  gsb_ctl_regs #(.NPIN(NPIN)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .frame_stb (frame_stb),
    .ctl_valid (ctl_valid),
    .ctl_bits  (ctl_slot[PIN_MSB:PIN_LSB]),
    .cfg_we    (cfg_we),
    .cfg_sel   (cfg_sel_e'(cfg_sel)),
    .cfg_wdata (cfg_wdata),
    .dir_q     (dir_q),
    .data_q    (data_q),
    .ien_q     (ien_q)
  );

  gsb_irq #(.NPIN(NPIN)) u_irq (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .frame_stb (frame_stb),
    .pin_sync  (pin_sync),
    .dir_q     (dir_q),
    .ien_q     (ien_q),
    .clr_we    (irq_clr_we),
    .clr_mask  (irq_clr_mask),
    .sticky_d  (sticky_d),
    .sticky_q  (sticky_q)
  );

  // status snapshot: one coherent word per frame
  always_comb begin
    sta_d = sta_q;
    if (frame_stb) begin
      sta_d                  = '0;
      sta_d[PIN_MSB:PIN_LSB] = pin_sync;
      sta_d[FLAG_BIT]        = |sticky_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i)       sta_q <= '0;
    else if (frame_stb) sta_q <= sta_d;
  end

  assign sta_slot = sta_q;
  assign pin_out  = data_q;
  assign pin_oe   = dir_q;
  assign irq      = |sticky_q;
endmodule

// File: rtl/gsb_chk.sv
module gsb_chk #(
  parameter int NPIN = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            frame_stb,
  input logic [19:0]     sta_slot,
  input logic            cfg_we,
  input logic [1:0]      cfg_sel,
  input logic [NPIN-1:0] cfg_wdata,
  input logic            irq_clr_we,
  input logic [NPIN-1:0] irq_clr_mask,
  input logic            irq,
  input logic [NPIN-1:0] pin_out,
  input logic [NPIN-1:0] pin_oe
);
  // R1
  reset_tristate_chk: assert property (@(posedge clk) !rst_n |=> (pin_oe == '0));

  // R2
  dir_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_sel == 2'd0) |=> (pin_oe == $past(cfg_wdata)));

  // R3
  data_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_sel == 2'd1) |=> (pin_out == $past(cfg_wdata)));

  // R5
  input_bits_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_stb && !(cfg_we && cfg_sel == 2'd1))
      |=> (((pin_out ^ $past(pin_out)) & ~$past(pin_oe)) == '0));

  // R6
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_stb && !(cfg_we && cfg_sel == 2'd1)) |=> $stable(pin_out));

  // R7
  status_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_stb |=> $stable(sta_slot));

  // R9
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sta_slot[3:1] == 3'b000));

  // R12
  clear_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_clr_we && (&irq_clr_mask) && !frame_stb) |=> !irq);
endmodule

bind gpio_slot_bridge gsb_chk #(.NPIN(NPIN)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .frame_stb    (frame_stb),
  .sta_slot     (sta_slot),
  .cfg_we       (cfg_we),
  .cfg_sel      (cfg_sel),
  .cfg_wdata    (cfg_wdata),
  .irq_clr_we   (irq_clr_we),
  .irq_clr_mask (irq_clr_mask),
  .irq          (irq),
  .pin_out      (pin_out),
  .pin_oe       (pin_oe)
);

// File: tb/gpio_slot_bridge_tb.sv
`timescale 1ns/1ps
module gpio_slot_bridge_tb;
  localparam int NP = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          frame_stb = 1'b0;
  logic [19:0]   ctl_slot = '0;
  logic          ctl_valid = 1'b0;
  logic [19:0]   sta_slot;
  logic          cfg_we = 1'b0;
  logic [1:0]    cfg_sel = 2'd3;
  logic [NP-1:0] cfg_wdata = '0;
  logic          irq_clr_we = 1'b0;
  logic [NP-1:0] irq_clr_mask = '0;
  logic          irq;
  logic [NP-1:0] pin_in, pin_out, pin_oe;
  logic [NP-1:0] ext = '0;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  // pads: driven pins read back their own drive, others read the outside level
  assign pin_in = (pin_oe & pin_out) | (~pin_oe & ext);

  gpio_slot_bridge #(.NPIN(NP)) u_dut (
    .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb),
    .ctl_slot(ctl_slot), .ctl_valid(ctl_valid), .sta_slot(sta_slot),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .irq_clr_we(irq_clr_we), .irq_clr_mask(irq_clr_mask), .irq(irq),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int m_dir, m_data, m_ien, m_pend, m_sticky, m_prev;
  bit m_pendv, m_primed;
  int m_sta;
  int m_sync[$];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_dir = 0; m_data = 0; m_ien = 0; m_pend = 0; m_pendv = 0;
      m_sticky = 0; m_prev = 0; m_primed = 0; m_sta = 0;
      m_sync = '{0, 0};
    end else begin
      int pad, lvl, setv, nd, ns;
      pad = ((m_dir & m_data) | (~m_dir & int'(ext))) & 'hFF;
      lvl = m_sync[0];
      setv = 0;
      if (frame_stb && m_primed) setv = (lvl ^ m_prev) & ~m_dir & m_ien & 'hFF;
      ns = m_sticky;
      if (irq_clr_we) ns = ns & ~int'(irq_clr_mask);
      ns = ns | setv;
      nd = m_data;
      if (frame_stb && m_pendv) nd = (m_data & ~m_dir) | (m_pend & m_dir);
      if (cfg_we && cfg_sel == 2'd1) nd = int'(cfg_wdata);
      if (cfg_we && cfg_sel == 2'd0) m_dir = int'(cfg_wdata);
      if (cfg_we && cfg_sel == 2'd2) m_ien = int'(cfg_wdata);
      if (frame_stb) begin
        m_sta = (lvl << 4) | ((ns != 0) ? 1 : 0);
        m_prev = lvl;
        m_primed = 1;
      end
      if (ctl_valid) begin
        m_pend = int'(ctl_slot[11:4]);
        m_pendv = 1;
      end else if (frame_stb) begin
        m_pendv = 0;
      end
      m_data = nd & 'hFF;
      m_sticky = ns & 'hFF;
      void'(m_sync.pop_front());
      m_sync.push_back(pad);
    end
  end

  always @(posedge clk) begin
    #2;
    if (rst_n) begin
      chk("R2 pin_oe vs model", 32'(pin_oe), 32'(m_dir));
      chk("R4 pin_out vs model", 32'(pin_out), 32'(m_data));
      chk("R7 sta_slot vs model", 32'(sta_slot), 32'(m_sta));
      chk("R11 irq vs model", 32'(irq), 32'(m_sticky != 0));
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic frame();
    @(negedge clk) frame_stb = 1'b1;
    @(negedge clk) frame_stb = 1'b0;
  endtask

  task automatic cfg(input logic [1:0] sel, input logic [NP-1:0] val);
    @(negedge clk) begin cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = val; end
    @(negedge clk) begin cfg_we = 1'b0; cfg_sel = 2'd3; end
  endtask

  task automatic slot(input logic [19:0] w);
    @(negedge clk) begin ctl_valid = 1'b1; ctl_slot = w; end
    @(negedge clk) ctl_valid = 1'b0;
  endtask

  initial begin
    #(8 * 20000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(4);
    // R1 reset state
    chk("R1 pin_oe", 32'(pin_oe), 0);
    chk("R1 pin_out", 32'(pin_out), 0);
    chk("R1 sta_slot", 32'(sta_slot), 0);
    chk("R1 irq", 32'(irq), 0);

    // R10 priming: level already high at first strobe sets nothing
    cfg(2'd2, 8'hFF);
    ext = 8'h80;
    cyc(4);
    frame();
    chk("R10 no flag on first strobe", 32'(irq), 0);
    chk("R7 first snapshot", 32'(sta_slot), 32'h00800);

    // R3 data writable as input, R2 direction enables drive
    cfg(2'd1, 8'hA5);
    chk("R3 data loaded while input", 32'(pin_out), 32'hA5);
    chk("R3 still tristated", 32'(pin_oe), 0);
    cfg(2'd0, 8'h0F);
    chk("R2 direction", 32'(pin_oe), 32'h0F);
    cyc(4);
    frame();
    chk("R7 pad snapshot", 32'(sta_slot), 32'h00850);
    chk("R10 output pin change no flag", 32'(irq), 0);

    // R4 / R5 slot word applied at the next strobe, output pins only
    slot(20'h003C0);
    chk("R4 not before strobe", 32'(pin_out), 32'hA5);
    frame();
    chk("R4 applied at strobe", 32'(pin_out), 32'hAC);
    chk("R5 input bits untouched", 32'(pin_out[7:4]), 32'hA);
    chk("R8 same-frame status old", 32'(sta_slot), 32'h00850);
    cyc(4);
    frame();
    chk("R8 next frame status new", 32'(sta_slot), 32'h008C0);
    chk("R6 hold without slot", 32'(pin_out), 32'hAC);

    // R10 / R11 change detect with per-pin enable
    cfg(2'd2, 8'h1F);
    ext = 8'hD0;
    cyc(4);
    frame();
    chk("R10 enabled pin flagged", 32'(irq), 1);
    chk("R11 status flag bit", 32'(sta_slot), 32'h00DC1);

    // R12 clear and set in the same cycle: set wins
    cfg(2'd2, 8'hFF);
    ext = 8'h90;
    cyc(4);
    @(negedge clk) begin frame_stb = 1'b1; irq_clr_we = 1'b1; irq_clr_mask = 8'h50; end
    @(negedge clk) begin frame_stb = 1'b0; irq_clr_we = 1'b0; irq_clr_mask = '0; end
    chk("R12 set beats clear", 32'(irq), 1);
    chk("R11 status after collision", 32'(sta_slot), 32'h009C1);
    @(negedge clk) begin irq_clr_we = 1'b1; irq_clr_mask = 8'h40; end
    @(negedge clk) begin irq_clr_we = 1'b0; irq_clr_mask = '0; end
    chk("R12 cleared", 32'(irq), 0);
    cyc(3);
    frame();
    chk("R11 status flag cleared", 32'(sta_slot), 32'h009C0);

    // R13 write port beats pending slot word
    slot(20'h00000);
    @(negedge clk) begin frame_stb = 1'b1; cfg_we = 1'b1; cfg_sel = 2'd1; cfg_wdata = 8'h5A; end
    @(negedge clk) begin frame_stb = 1'b0; cfg_we = 1'b0; cfg_sel = 2'd3; end
    chk("R13 write port wins", 32'(pin_out), 32'h5A);

    // R4 word valid on the strobe cycle waits one frame
    cyc(3);
    @(negedge clk) begin frame_stb = 1'b1; ctl_valid = 1'b1; ctl_slot = 20'h000F0; end
    @(negedge clk) begin frame_stb = 1'b0; ctl_valid = 1'b0; end
    chk("R4 coincident word deferred", 32'(pin_out), 32'h5A);
    cyc(4);
    frame();
    chk("R4 coincident word applied", 32'(pin_out), 32'h5F);

    // R9 reserved bits
    chk("R9 reserved zero", 32'(sta_slot & 20'hFF00E), 0);
    cyc(4);
    frame();
    chk("R9 reserved zero later", 32'(sta_slot & 20'hFF00E), 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule